// File: doc/BRIEF.md
# Two-Phase Interleaved PWM Generator

The block turns one digitized error command into two pulse-width-modulated gate commands for a two-phase buck converter. A single free-running counter serves as the sawtooth. The second phase reads it shifted by half a period, so its pulses are interleaved with those of the first phase. Each phase adds its own signed trim to the shared command. The trim is derived from how far that phase's sampled current sits from the mean of the two currents, so the hotter phase gets a narrower pulse.

A mode input from the start-up sequencer selects one of three states. In the first, both outputs are released (enable low). In the second, both are driven low so the low-side switches conduct. In the third, normal modulation runs. Each phase also emits a one-clock strobe that tells the current-sensing front end when to sample: one third of a period after that phase's pulse ends. Duty updates take effect only at a phase boundary, so no period ever carries a truncated or doubled pulse.

Top module: `pwm2_interleave`

## Requirements
- R1: While rst_ni is low, the counter is held at 0 and both stored duties are 0, so pwm_o and smp_o are both 0.
- R2: The shared counter counts 0 to PERIOD-1 and wraps. In run mode, phase A's period starts at count 0, and each phase's pwm bit is high for the first D clocks of its own period, where D is its stored duty. A larger command never gives a narrower pulse.
- R3: Phase B's period starts at count PERIOD/2, so its rising edges trail phase A's by PERIOD/2 clocks.
- R4: A phase's new duty is cmd - ((i_own - floor((i_a+i_b)/2)) >>> GAIN_SH). The subtraction is signed and the shift is arithmetic, rounding toward minus infinity. A phase above the mean loses width and a phase below the mean gains it.
- R5: The corrected duty is clamped to 0..PERIOD-1. PERIOD-1 gives a pulse that is high for all but the last clock, and 0 gives no pulse.
- R6: A phase's duty register loads only on the clock edge that ends the last clock (local count PERIOD-1) of that phase's period. A command or current change in mid-period leaves the current pulse unchanged.
- R7: In run mode, smp_o[k] is a one-clock pulse once per period of phase k, at local count min(D + PERIOD/3, PERIOD-1), with PERIOD/3 rounded down.
- R8: mode_i = 2'b00 or 2'b11 releases the outputs: pwm_oe_o = 2'b00, pwm_o = 0 and smp_o = 0.
- R9: mode_i = 2'b01 forces low: pwm_oe_o = 2'b11, pwm_o = 0 and smp_o = 0. The counter and the duty loading keep running, so returning to run (2'b10) resumes at the correct phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| mode_i | input | 2 | 00/11 release, 01 force low, 10 run |
| duty_cmd_i | input | $clog2(PERIOD) | Unsigned error command, duty in clocks |
| cur_a_i | input | CUR_W | Sampled current, phase A, unsigned |
| cur_b_i | input | CUR_W | Sampled current, phase B, unsigned |
| pwm_o | output | 2 | Gate command, bit 0 phase A, bit 1 phase B |
| pwm_oe_o | output | 2 | Output enable per phase; low means tri-state |
| smp_o | output | 2 | Current-sample strobe per phase |

## Verification
The embedded properties check several things every cycle: the counter wrap, that phase B only rises at count PERIOD/2 during steady run, that a stored duty never leaves its range or changes outside its load slot, that strobes last one clock, and that released or forced-low outputs stay quiet. The correction arithmetic can only be shown by the bench scenarios. This includes the floor rounding of negative deviations, both clamp limits, and a command change landing mid-period. The same holds for the exact strobe distance from the falling edge and the resumption of correct phasing after a forced-low interval.

// File: rtl/pwm2_pkg.sv
package pwm2_pkg;
  typedef enum logic [1:0] {
    MODE_OFF  = 2'b00,
    MODE_LOW  = 2'b01,
    MODE_RUN  = 2'b10,
    MODE_OFF2 = 2'b11
  } pwm_mode_e;
endpackage

// File: rtl/pwm2_trim.sv
module pwm2_trim #(
  parameter int PERIOD  = 256,
  parameter int CNT_W   = 8,
  parameter int CUR_W   = 10,
  parameter int GAIN_SH = 2
) (
  input  logic [CNT_W-1:0] cmd_i,
  input  logic [CUR_W-1:0] own_i,
  input  logic [CUR_W-1:0] other_i,
  output logic [CNT_W-1:0] duty_o
);
  localparam int SUM_W = ((CNT_W > CUR_W) ? CNT_W : CUR_W) + 3;
  localparam logic signed [SUM_W-1:0] TOP = SUM_W'(PERIOD - 1);

  logic        [CUR_W:0]   pair_sum;
  logic        [CUR_W-1:0] avg;
  logic signed [CUR_W+1:0] dev;
  logic signed [CUR_W+1:0] corr;
  logic signed [SUM_W-1:0] corr_x;
  logic signed [SUM_W-1:0] raw;

  always_comb begin
    pair_sum = {1'b0, own_i} + {1'b0, other_i};
    avg      = CUR_W'(pair_sum >> 1);
    dev      = $signed({2'b00, own_i}) - $signed({2'b00, avg});
    corr     = dev >>> GAIN_SH;   // arithmetic: floors negatives
    corr_x   = SUM_W'(corr);
    raw      = $signed({{(SUM_W-CNT_W){1'b0}}, cmd_i}) - corr_x;
    if (raw < 0)        duty_o = '0;
    else if (raw > TOP) duty_o = CNT_W'(PERIOD - 1);
    else                duty_o = CNT_W'(raw);
  end
endmodule

// File: rtl/pwm2_chan.sv
module pwm2_chan #(
  parameter int PERIOD = 256,
  parameter int CNT_W  = 8,
  parameter int OFFSET = 0
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [CNT_W-1:0] base_cnt_i,
  input  logic [CNT_W-1:0] duty_i,
  input  logic             run_i,
  output logic             pwm_o,
  output logic             smp_o
);
  localparam int               THIRD = PERIOD / 3;
  localparam logic [CNT_W-1:0] LAST  = CNT_W'(PERIOD - 1);

  logic [CNT_W:0]   shifted;
  logic [CNT_W-1:0] local_cnt;
  logic [CNT_W-1:0] duty_q;
  logic [CNT_W:0]   spot;
  logic [CNT_W-1:0] smp_at;

  always_comb begin
    shifted   = {1'b0, base_cnt_i} + (CNT_W+1)'(OFFSET);
    local_cnt = (shifted >= (CNT_W+1)'(PERIOD)) ? CNT_W'(shifted - (CNT_W+1)'(PERIOD))
                                                : CNT_W'(shifted);
    spot      = {1'b0, duty_q} + (CNT_W+1)'(THIRD);
    smp_at    = (spot > (CNT_W+1)'(PERIOD - 1)) ? LAST : CNT_W'(spot);
  end

  // load on the last clock so the new width owns the whole next period
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                duty_q <= '0;
    else if (local_cnt == LAST) duty_q <= duty_i;
  end

  assign pwm_o = run_i && (local_cnt < duty_q);
  assign smp_o = run_i && (local_cnt == smp_at);

  assert_duty_range_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    duty_q <= LAST);
  assert_duty_hold_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (local_cnt != '0) |-> $stable(duty_q));
  assert_smp_pulse_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    smp_o |=> !smp_o);
endmodule

// File: rtl/pwm2_interleave.sv
module pwm2_interleave #(
  parameter int PERIOD  = 256,
  parameter int CUR_W   = 10,
  parameter int GAIN_SH = 2,
  localparam int CNT_W  = $clog2(PERIOD)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [1:0]       mode_i,
  input  logic [CNT_W-1:0] duty_cmd_i,
  input  logic [CUR_W-1:0] cur_a_i,
  input  logic [CUR_W-1:0] cur_b_i,
  output logic [1:0]       pwm_o,
  output logic [1:0]       pwm_oe_o,
  output logic [1:0]       smp_o
);
  import pwm2_pkg::*;

  localparam int               HALF = PERIOD / 2;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(PERIOD - 1);

  logic [CNT_W-1:0] cnt_q;
  logic [CUR_W-1:0] cur [2];
  logic [CNT_W-1:0] duty_new [2];
  logic             run;
  logic             drive;

  assign cur[0] = cur_a_i;
  assign cur[1] = cur_b_i;
  assign run    = (mode_i == MODE_RUN);
  assign drive  = (mode_i == MODE_RUN) || (mode_i == MODE_LOW);
  assign pwm_oe_o = {2{drive}};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             cnt_q <= '0;
    else if (cnt_q == LAST)  cnt_q <= '0;
    else                     cnt_q <= cnt_q + 1'b1;
  end

  for (genvar k = 0; k < 2; k++) begin : g_ph
    pwm2_trim #(.PERIOD(PERIOD), .CNT_W(CNT_W), .CUR_W(CUR_W), .GAIN_SH(GAIN_SH)) u_trim (
      .cmd_i   (duty_cmd_i),
      .own_i   (cur[k]),
      .other_i (cur[1-k]),
      .duty_o  (duty_new[k])
    );
    pwm2_chan #(.PERIOD(PERIOD), .CNT_W(CNT_W),
                .OFFSET((k == 0) ? 0 : PERIOD - HALF)) u_chan (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .base_cnt_i (cnt_q),
      .duty_i     (duty_new[k]),
      .run_i      (run),
      .pwm_o      (pwm_o[k]),
      .smp_o      (smp_o[k])
    );
  end

  assert_cnt_wrap_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_q == LAST) |=> (cnt_q == '0));
  assert_b_rise_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run && $past(run) && $rose(pwm_o[1])) |-> (cnt_q == CNT_W'(HALF)));
  assert_quiet_off_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pwm_oe_o == 2'b00) |-> (pwm_o == 2'b00 && smp_o == 2'b00));
  assert_force_low_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == MODE_LOW) |-> (pwm_o == 2'b00 && smp_o == 2'b00 && pwm_oe_o == 2'b11));
endmodule

// File: tb/sim_pwm2_interleave.sv
`timescale 1ns/100ps
module sim_pwm2_interleave;
  localparam int PERIOD = 256;
  localparam int CUR_W  = 10;
  localparam int G      = 2;
  localparam int CW     = $clog2(PERIOD);
  localparam int HALF   = PERIOD / 2;
  localparam int THIRD  = PERIOD / 3;

  logic clk = 0;
  logic rst_n = 0;
  logic [1:0] mode = 2'b10;
  logic [CW-1:0] cmd = 64;
  logic [CUR_W-1:0] ca = 100, cb = 100;
  logic [1:0] pwm, oe, smp;
  int total = 0, bad = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  pwm2_interleave #(.PERIOD(PERIOD), .CUR_W(CUR_W), .GAIN_SH(G)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .mode_i(mode), .duty_cmd_i(cmd),
    .cur_a_i(ca), .cur_b_i(cb), .pwm_o(pwm), .pwm_oe_o(oe), .smp_o(smp));

  task automatic check(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int model_duty(input int c, input int own, input int oth);
    int avg, dev, corr, raw, d;
    avg = (own + oth) / 2;
    dev = own - avg;
    d = 1 << G;
    corr = (dev >= 0) ? dev / d : -((-dev + d - 1) / d);
    raw = c - corr;
    if (raw < 0) raw = 0;
    if (raw > PERIOD - 1) raw = PERIOD - 1;
    return raw;
  endfunction

  // reference model
  int m_cnt, m_d0, m_d1;
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_cnt = 0; m_d0 = 0; m_d1 = 0;
    end else begin
      if (m_cnt == PERIOD - 1) m_d0 = model_duty(cmd, ca, cb);
      if ((m_cnt + PERIOD - HALF) % PERIOD == PERIOD - 1) m_d1 = model_duty(cmd, cb, ca);
      m_cnt = (m_cnt + 1) % PERIOD;
    end
  end

  always @(negedge clk) begin
    if (rst_n && !done) begin
      int l0, l1, e_p, e_s, e_oe;
      l0 = m_cnt;
      l1 = (m_cnt + PERIOD - HALF) % PERIOD;
      e_oe = (mode == 2'b10 || mode == 2'b01) ? 3 : 0;
      e_p = 0; e_s = 0;
      if (mode == 2'b10) begin
        e_p = ((l1 < m_d1) ? 2 : 0) | ((l0 < m_d0) ? 1 : 0);
        e_s = ((l1 == ((m_d1 + THIRD > PERIOD-1) ? PERIOD-1 : m_d1 + THIRD)) ? 2 : 0)
            | ((l0 == ((m_d0 + THIRD > PERIOD-1) ? PERIOD-1 : m_d0 + THIRD)) ? 1 : 0);
      end
      check("R2 R4 R6 pwm per cycle", int'(pwm), e_p);
      check("R7 strobe per cycle", int'(smp), e_s);
      check("R8 R9 enable per cycle", int'(oe), e_oe);
    end
  end

  task automatic window(input int n, output int h0, output int h1,
                        output int s0, output int s1, output int oe_ones);
    h0 = 0; h1 = 0; s0 = 0; s1 = 0; oe_ones = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      h0 += int'(pwm[0]); h1 += int'(pwm[1]);
      s0 += int'(smp[0]); s1 += int'(smp[1]);
      oe_ones += int'(oe[0]) + int'(oe[1]);
    end
  endtask

  task automatic wait_rise0();
    logic prev;
    prev = pwm[0];
    forever begin
      @(negedge clk);
      if (pwm[0] && !prev) break;
      prev = pwm[0];
    end
  endtask

  initial begin
    int h0, h1, s0, s1, oes, gap;
    logic prev;
    repeat (3) @(negedge clk);
    check("R1 reset pwm", int'(pwm), 0);
    check("R1 reset strobe", int'(smp), 0);
    rst_n = 1;

    // equal currents, cmd 64
    repeat (2*PERIOD) @(negedge clk);
    window(PERIOD, h0, h1, s0, s1, oes);
    check("R2 width A", h0, 64);
    check("R2 width B", h1, 64);
    check("R7 one strobe A", s0, 1);
    check("R7 one strobe B", s1, 1);

    wait_rise0();
    gap = 0; prev = pwm[1];
    forever begin
      @(negedge clk); gap++;
      if (pwm[1] && !prev) break;
      prev = pwm[1];
    end
    check("R3 A-to-B rise gap", gap, HALF);

    prev = pwm[0];
    forever begin
      @(negedge clk);
      if (!pwm[0] && prev) break;
      prev = pwm[0];
    end
    gap = 0;
    while (!smp[0]) begin @(negedge clk); gap++; end
    check("R7 fall-to-strobe", gap, THIRD);

    // imbalance: A hotter -> 52, B -> 77
    ca = 200; cb = 100;
    repeat (2*PERIOD) @(negedge clk);
    window(PERIOD, h0, h1, s0, s1, oes);
    check("R4 hot phase narrowed", h0, 52);
    check("R4 cool phase widened", h1, 77);

    // upper clamp
    cmd = 250; ca = 100; cb = 200;
    repeat (2*PERIOD) @(negedge clk);
    window(PERIOD, h0, h1, s0, s1, oes);
    check("R5 clamp top", h0, 255);
    check("R5 unclamped partner", h1, 238);

    // lower clamp
    cmd = 5; ca = 200; cb = 100;
    repeat (2*PERIOD) @(negedge clk);
    window(PERIOD, h0, h1, s0, s1, oes);
    check("R5 clamp zero", h0, 0);
    check("R5 partner", h1, 18);
    check("R7 strobe at zero duty", s0, 1);

    // mid-period command change
    cmd = 40; ca = 100; cb = 100;
    repeat (2*PERIOD) @(negedge clk);
    wait_rise0();
    cmd = 200;
    h0 = 1;
    for (int i = 1; i < PERIOD; i++) begin @(negedge clk); h0 += int'(pwm[0]); end
    check("R6 current period kept", h0, 40);
    window(PERIOD, h0, h1, s0, s1, oes);
    check("R6 next period updated", h0, 200);

    // release modes
    mode = 2'b00;
    window(PERIOD, h0, h1, s0, s1, oes);
    check("R8 mode 00 enable", oes, 0);
    check("R8 mode 00 pulses", h0 + h1 + s0 + s1, 0);
    mode = 2'b11;
    window(PERIOD, h0, h1, s0, s1, oes);
    check("R8 mode 11 enable", oes, 0);
    check("R8 mode 11 pulses", h0 + h1 + s0 + s1, 0);

    // forced low
    mode = 2'b01;
    window(PERIOD, h0, h1, s0, s1, oes);
    check("R9 forced-low enable", oes, 2*PERIOD);
    check("R9 forced-low pulses", h0 + h1 + s0 + s1, 0);
    mode = 2'b10;
    repeat (PERIOD) @(negedge clk);
    wait_rise0();
    gap = 0; prev = pwm[1];
    forever begin
      @(negedge clk); gap++;
      if (pwm[1] && !prev) break;
      prev = pwm[1];
    end
    check("R9 phasing after resume", gap, HALF);

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      bad++; total++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule